// File: doc/BRIEF.md
# Dual Retriggerable One-Shot

This block is a clocked, fully digital pulse stretcher with two identical, independent channels. Each channel watches three asynchronous inputs: a trigger that fires on its falling edge, a trigger that fires on its rising edge, and an active-low clear. When a trigger is accepted, the channel drives a high pulse on `q_o` for a programmable number of clock cycles. Its complement `qn_o` is driven alongside it. A length input per channel takes the place of the resistor and capacitor that would set the timing in an analog circuit.

Every input passes through a two-flop synchroniser before its edges are detected. Each trigger edge is gated by the levels of the other two inputs. A new accepted trigger reloads the full length, so a pulse that is already running is stretched. Holding the clear low ends the pulse and keeps the channel quiet. A parameter decides whether releasing the clear may itself start a pulse. A programmable minimum spacing between accepted triggers rejects edges that come too close together.

Top module: `oneshot_pair`

## Requirements
- R1: A falling edge on `trig_fall_i[i]` starts a pulse on channel i only if, at that moment, `trig_rise_i[i]` is high and `clr_n_i[i]` is high. With `trig_rise_i[i]` low the edge has no effect.
- R2: A rising edge on `trig_rise_i[i]` starts a pulse only if `trig_fall_i[i]` is low and `clr_n_i[i]` is high. With `trig_fall_i[i]` high the edge has no effect.
- R3: An input change made in cycle c produces an accepted trigger that raises `q_o[i]` from cycle c+3. The output then stays high for exactly the channel's length value of cycles after the last accepted trigger. An accepted trigger during a pulse reloads the full length, which extends the pulse.
- R4: While the synchronised `clr_n_i[i]` is low, the counter is cleared and `q_o[i]` is low from the third cycle after the clear was driven low. No trigger is accepted while the clear is low.
- R5: With `REL_FIRE`=1 (the default), a rising edge on `clr_n_i[i]` while `trig_fall_i[i]` is low and `trig_rise_i[i]` is high starts a pulse. With `REL_FIRE`=0, a clear release never starts a pulse.
- R6: `qn_o` is always the bitwise inverse of `q_o`.
- R7: A trigger is accepted only if at least `gap_i` cycles have passed since the previous accepted trigger on that channel. A `gap_i` of 0 or 1 accepts every trigger. A rejected trigger does not extend the pulse.
- R8: While `rst` is high, both channels are idle with `q_o` low. The edge history is loaded from the current inputs, so trigger-ready levels that are present at reset release produce no pulse.
- R9: The two channels are independent. Channel i uses bits `[i]` of each trigger and clear input and its own length `len_i[i*LEN_W +: LEN_W]`.
- R10: A length value of 0 makes an accepted trigger produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_fall_i | input | NCH | Falling-edge trigger, one per channel |
| trig_rise_i | input | NCH | Rising-edge trigger, one per channel |
| clr_n_i | input | NCH | Active-low clear, one per channel |
| len_i | input | NCH*LEN_W | Pulse length in cycles, one field per channel |
| gap_i | input | GAP_W | Minimum cycles between accepted triggers |
| q_o | output | NCH | Pulse output, high while active |
| qn_o | output | NCH | Inverse of q_o |

## Verification
The hardest situation to reach is a trigger edge that arrives while the clear is held low, followed by a clear release that has to fire on its own. The trigger levels must be arranged so that the ignored edge leaves exactly the release condition behind (rise input high, fall input low). The stimulus starts a long pulse and lowers the clear in the middle of it. It then toggles the rise input while the clear is low, and releases the clear. The expected output must show the early cut-off, the ignored edge, and a fresh full-length pulse three cycles after the release. Spacing rejection is reached by bunching rise edges three cycles apart and then exactly five cycles apart, with a gap value of 5.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronised levels of one channel's three inputs
    typedef struct packed {
        logic fa;   // falling-edge trigger level
        logic rb;   // rising-edge trigger level
        logic cn;   // active-low clear level
    } pins_t;

    // Edges seen on one channel in the current cycle
    typedef struct packed {
        logic fa_fall;
        logic rb_rise;
        logic cn_rise;
    } edges_t;

    // A trigger is valid when an edge coincides with the gating levels
    function automatic logic qualify(pins_t cur, edges_t e, logic rel_en);
        logic by_fall;
        logic by_rise;
        logic by_rel;
        by_fall = e.fa_fall & cur.rb & cur.cn;
        by_rise = e.rb_rise & ~cur.fa & cur.cn;
        by_rel  = rel_en & e.cn_rise & ~cur.fa & cur.rb;
        return by_fall | by_rise | by_rel;
    endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync
    import oneshot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t d,
    output pins_t q
);
    pins_t s1;

    // Two-stage synchroniser; both stages are filled with the live input during reset
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= d;
            q  <= d;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
    import oneshot_pkg::*;
#(
    parameter bit REL_FIRE = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t cur,
    output logic  hit
);
    pins_t  prev;
    edges_t e;

    always_ff @(posedge clk) begin
        prev <= cur;   // the same load in and out of reset keeps the history equal to the inputs
    end

    always_comb begin
        e.fa_fall = prev.fa & ~cur.fa;
        e.rb_rise = ~prev.rb & cur.rb;
        e.cn_rise = ~prev.cn & cur.cn;
        hit = ~rst & qualify(cur, e, REL_FIRE);
    end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int LEN_W = 8,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             hit,
    input  logic [LEN_W-1:0] len,
    input  logic [GAP_W-1:0] gap,
    output logic             accept,
    output logic             active
);
    localparam logic [GAP_W-1:0] SINCE_MAX = {GAP_W{1'b1}};
    localparam logic [GAP_W-1:0] SINCE_ONE = GAP_W'(1);

    logic [LEN_W-1:0] cnt;
    logic [GAP_W-1:0] since;

    // Cycles since the last accepted trigger, saturating
    assign accept = hit & (since >= gap);
    assign active = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= SINCE_MAX;
        end else if (accept) begin
            since <= SINCE_ONE;
        end else if (since != SINCE_MAX) begin
            since <= since + SINCE_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !clr_n) begin
            cnt <= '0;
        end else if (accept) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
        end
    end
endmodule

// File: rtl/oneshot_pair.sv
module oneshot_pair
    import oneshot_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int LEN_W    = 8,
    parameter int GAP_W    = 4,
    parameter bit REL_FIRE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       trig_fall_i,
    input  logic [NCH-1:0]       trig_rise_i,
    input  logic [NCH-1:0]       clr_n_i,
    input  logic [NCH*LEN_W-1:0] len_i,
    input  logic [GAP_W-1:0]     gap_i,
    output logic [NCH-1:0]       q_o,
    output logic [NCH-1:0]       qn_o
);
    logic [NCH-1:0] rs_s;   // synchronised clear per channel
    logic [NCH-1:0] acc;    // accepted trigger per channel

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pins_t raw;
        pins_t syn;
        logic  hit;

        assign raw = '{fa: trig_fall_i[i], rb: trig_rise_i[i], cn: clr_n_i[i]};

        oneshot_sync u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw),
            .q   (syn)
        );

        oneshot_edge #(.REL_FIRE(REL_FIRE)) u_edge (
            .clk (clk),
            .rst (rst),
            .cur (syn),
            .hit (hit)
        );

        oneshot_timer #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .clr_n  (syn.cn),
            .hit    (hit),
            .len    (len_i[i*LEN_W +: LEN_W]),
            .gap    (gap_i),
            .accept (acc[i]),
            .active (q_o[i])
        );

        assign rs_s[i] = syn.cn;
        assign qn_o[i] = ~q_o[i];
    end
endmodule

// File: rtl/oneshot_pair_chk.sv
module oneshot_pair_chk #(
    parameter int NCH   = 2,
    parameter int LEN_W = 8,
    parameter int GAP_W = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NCH-1:0]       rs_s,
    input logic [NCH-1:0]       acc,
    input logic [NCH*LEN_W-1:0] len_i,
    input logic [GAP_W-1:0]     gap_i,
    input logic [NCH-1:0]       q_o,
    input logic [NCH-1:0]       qn_o
);
    // R6: outputs always complementary
    a_r6_complement: assert property (@(posedge clk) disable iff (rst)
        qn_o == ~q_o);

    // R8: reset leaves every channel idle
    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> (q_o == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R4: a low synchronised clear forces the output low next cycle
        a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
            !rs_s[i] |=> !q_o[i]);

        // R3 / R10: an accepted trigger yields a pulse exactly when the length is nonzero
        a_r3_reload: assert property (@(posedge clk) disable iff (rst)
            acc[i] |=> (q_o[i] == ($past(len_i[i*LEN_W +: LEN_W]) != '0)));

        // R7: with a spacing above one, two accepts cannot be adjacent
        a_r7_spacing: assert property (@(posedge clk) disable iff (rst)
            (acc[i] && gap_i > GAP_W'(1)) |=> (!acc[i] || gap_i <= GAP_W'(1)));

        // R4: no trigger is accepted while the clear is low
        a_r4_no_accept: assert property (@(posedge clk) disable iff (rst)
            !rs_s[i] |-> !acc[i]);
    end
endmodule

bind oneshot_pair oneshot_pair_chk #(
    .NCH   (NCH),
    .LEN_W (LEN_W),
    .GAP_W (GAP_W)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .rs_s  (rs_s),
    .acc   (acc),
    .len_i (len_i),
    .gap_i (gap_i),
    .q_o   (q_o),
    .qn_o  (qn_o)
);

// File: tb/oneshot_pair_tb_top.sv
module oneshot_pair_tb_top;
    localparam int NCH   = 2;
    localparam int LEN_W = 8;
    localparam int GAP_W = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NCH-1:0]       a   = 2'b00;
    logic [NCH-1:0]       b   = 2'b11;
    logic [NCH-1:0]       r   = 2'b11;
    logic [LEN_W-1:0]     len0 = 8'd6;
    logic [LEN_W-1:0]     len1 = 8'd3;
    logic [GAP_W-1:0]     gap = '0;
    logic [NCH-1:0]       q;
    logic [NCH-1:0]       qn;

    int cyc    = 0;
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int    at;
        int    ch;
        bit    val;
        string tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    oneshot_pair #(.NCH(NCH), .LEN_W(LEN_W), .GAP_W(GAP_W), .REL_FIRE(1'b1)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .trig_fall_i (a),
        .trig_rise_i (b),
        .clr_n_i     (r),
        .len_i       ({len1, len0}),
        .gap_i       (gap),
        .q_o         (q),
        .qn_o        (qn)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver side: push expected output values for a span of cycles
    task automatic expect_span(int ch, int from, int to, bit v, string tag);
        for (int k = from; k <= to; k++) begin
            item_t it;
            it.at = k; it.ch = ch; it.val = v; it.tag = tag;
            sb.push_back(it);
        end
    endtask

    // Monitor: pop due items and compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (q[it.ch] !== it.val || qn[it.ch] !== ~it.val) begin
                    errors++;
                    $display("FAIL %s ch%0d cycle %0d: q=%b qn=%b expected q=%b qn=%b",
                             it.tag, it.ch, cyc, q[it.ch], qn[it.ch], it.val, ~it.val);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c;
        // R8: reset with trigger-ready levels, no false pulse afterwards
        tick(3);
        rst = 1'b0;
        c = cyc;
        for (int k = c; k <= c + 8; k++) begin
            expect_span(0, k, k, 1'b0, "R8 idle after reset");
            expect_span(1, k, k, 1'b0, "R8 idle after reset");
        end
        tick(10);
        a = 2'b11; b = 2'b00;
        tick(6);

        // R2 gating: rise edge while the fall input is high does nothing
        c = cyc; b[0] = 1'b1;
        expect_span(0, c + 1, c + 8, 1'b0, "R2 rise ignored with fall input high");
        tick(10);

        // R1: falling edge with rise input high fires; R3 length and latency
        c = cyc; a[0] = 1'b0;
        expect_span(0, c + 1, c + 2, 1'b0, "R3 latency before pulse");
        expect_span(0, c + 3, c + 8, 1'b1, "R1 pulse from falling edge");
        expect_span(0, c + 9, c + 12, 1'b0, "R3 pulse ends after length");
        tick(14);

        // R1 gating: falling edge with rise input low does nothing
        a[0] = 1'b1; tick(3);
        b[0] = 1'b0; tick(3);
        c = cyc; a[0] = 1'b0;
        expect_span(0, c + 1, c + 8, 1'b0, "R1 fall ignored with rise input low");
        tick(10);

        // R2: rising edge with fall input low fires
        c = cyc; b[0] = 1'b1;
        expect_span(0, c + 1, c + 2, 1'b0, "R2 before pulse");
        expect_span(0, c + 3, c + 8, 1'b1, "R2 pulse from rising edge");
        expect_span(0, c + 9, c + 11, 1'b0, "R2 pulse ends");
        tick(12);
        b[0] = 1'b0; tick(4);

        // R3: retrigger four cycles later extends the pulse
        c = cyc; b[0] = 1'b1;
        expect_span(0, c + 1, c + 2, 1'b0, "R3 before pulse");
        expect_span(0, c + 3, c + 12, 1'b1, "R3 retrigger extends pulse");
        expect_span(0, c + 13, c + 14, 1'b0, "R3 extended pulse ends");
        tick(2); b[0] = 1'b0;
        tick(2); b[0] = 1'b1;
        tick(12);
        b[0] = 1'b0; tick(3);

        // R7: with gap 5 a trigger 3 cycles later is rejected
        gap = 4'd5;
        c = cyc; b[0] = 1'b1;
        expect_span(0, c + 1, c + 2, 1'b0, "R7 before pulse");
        expect_span(0, c + 3, c + 8, 1'b1, "R7 first trigger pulse");
        expect_span(0, c + 9, c + 10, 1'b0, "R7 close trigger did not extend");
        tick(1); b[0] = 1'b0;
        tick(2); b[0] = 1'b1;
        tick(9);
        b[0] = 1'b0; tick(3);

        // R7: a trigger exactly 5 cycles later is accepted
        c = cyc; b[0] = 1'b1;
        expect_span(0, c + 1, c + 2, 1'b0, "R7 before pulse");
        expect_span(0, c + 3, c + 13, 1'b1, "R7 spaced trigger extends");
        expect_span(0, c + 14, c + 15, 1'b0, "R7 spaced pulse ends");
        tick(2); b[0] = 1'b0;
        tick(3); b[0] = 1'b1;
        tick(12);
        b[0] = 1'b0; tick(3);
        gap = '0;

        // R4 and R5: clear cuts the pulse, blocks a trigger, release fires
        len0 = 8'd20;
        c = cyc; b[0] = 1'b1;
        expect_span(0, c + 1, c + 2, 1'b0, "R4 before pulse");
        expect_span(0, c + 3, c + 7, 1'b1, "R4 pulse before clear");
        expect_span(0, c + 8, c + 16, 1'b0, "R4 clear holds output low");
        expect_span(0, c + 17, c + 36, 1'b1, "R5 clear release fires");
        expect_span(0, c + 37, c + 38, 1'b0, "R5 release pulse ends");
        tick(5);  r[0] = 1'b0;
        tick(3);  b[0] = 1'b0;
        tick(2);  b[0] = 1'b1;
        tick(4);  r[0] = 1'b1;
        tick(26);
        b[0] = 1'b0; len0 = 8'd6;
        tick(3);

        // R9: channel 1 pulses with its own length while channel 0 stays idle
        b[1] = 1'b1; tick(3);
        c = cyc; a[1] = 1'b0;
        for (int k = c + 1; k <= c + 8; k++) begin
            expect_span(0, k, k, 1'b0, "R9 channel 0 untouched");
            expect_span(1, k, k, (k >= c + 3 && k <= c + 5), "R9 channel 1 own length");
        end
        tick(10);

        // R10: a length of zero produces no pulse
        len0 = '0;
        c = cyc; b[0] = 1'b1;
        expect_span(0, c + 1, c + 8, 1'b0, "R10 zero length no pulse");
        tick(10);

        tick(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule